// File: doc/BRIEF.md
# Timer Channel Byte Access Unit

This block sits between an 8-bit processor bus and one 16-bit down-counter of an interval timer. It holds everything the processor touches on that channel. That is the count register that stages a new initial count, the output latch that freezes a count for reading, and the status latch. It also holds the separate read and write byte pointers and the null-count flag. It applies the access format programmed by the last control word: low byte only, high byte only, or low then high. It acts on the count-latch and read-back commands that are aimed at its channel.

The surrounding logic decodes the address. It raises `cmd_we` for any write to the command address, `cnt_we` for a write to this channel's count port, and `cnt_re` for a read of it. At most one of these three strobes is high in a cycle. The counting element supplies `live_cnt`, `out_lvl` and `load_done`, and takes `cr_value` when `cr_done` pulses. Read data is combinational: `rdata` always shows the byte the next read will return, and a read strobe consumes it.

The block is built from four small state machines:
- Write pointer, with states W_LO and W_HI. W_LO→W_HI on the first byte in the two-byte format. W_HI→W_LO on the second byte or on a control word.
- Read pointer, with states RP_LO and RP_HI. It toggles on every count read in the two-byte format. A control word returns it to RP_LO.
- Output latch, with states OL_TRACK and OL_HOLD. OL_TRACK→OL_HOLD on a count latch. OL_HOLD→OL_TRACK on the final byte read or on a control word.
- Status latch, with states SL_EMPTY and SL_FULL. SL_EMPTY→SL_FULL on a status latch. SL_FULL→SL_EMPTY on the next read or on a control word.

Top module: `timer_chan_access`

## Requirements
- R1: A `cmd_we` byte addresses this channel when bits 7:6 equal CHAN_ID (default 1). If bits 5:4 are nonzero it is a control word: its bits 5:0 appear on `mode_byte` the next cycle. Bytes with another channel code leave `mode_byte` unchanged.
- R2: Bits 5:4 select the access format. With format 01 (low only), a count write gives `cr_value` = {00, data}. With format 10 (high only), it gives {data, 00}. In both cases `cr_done` pulses for one cycle after the write. A read returns the low byte for format 01 and the high byte for format 10, and never moves the read pointer.
- R3: In format 11 the first count write is staged and pulses `cr_first`, and `cr_value` keeps its old value. The second write updates both bytes of `cr_value` at once as {second, first} and pulses `cr_done`.
- R4: A command with bits 5:4 = 00 for this channel freezes the count. Reads return the frozen bytes until the count has been read in full in the programmed format, and then return the live count again. A repeat of the command before that point is ignored.
- R5: A read-back command (bits 7:6 = 11) applies when bit 1+CHAN_ID is set. Bit 5 = 0 latches the count and bit 4 = 0 latches the status. A repeated latch of either kind, issued before it has been read, is ignored. A read-back that does not select this channel has no effect.
- R6: The status byte is {OUT level, null count, last control bits 5:0}, captured when the status is latched.
- R7: When both status and count are latched, the first read returns the status. The next one or two reads return the latched count, and later reads return the live count.
- R8: Null count is set by a control word or by the completing count write (the second byte in format 11). It is cleared by `load_done`, and a set in the same cycle wins.
- R9: A control word cancels pending count and status latches and returns both byte pointers to the low byte.
- R10: The read and write pointers are independent. The sequence read low, write low, read high, write high returns both latched bytes and loads both written bytes.
- R11: After reset, `mode_byte` = 0x10 (format 01, mode 0, binary), `cr_value` = 0, null count = 0, and no latch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe to the command address |
| cnt_we | input | 1 | Write strobe to this channel's count port |
| cnt_re | input | 1 | Read strobe of this channel's count port |
| wdata | input | 8 | Write data byte |
| live_cnt | input | 16 | Current value of the counting element |
| out_lvl | input | 1 | Current level of the channel output |
| load_done | input | 1 | Pulse: count register moved into the counter |
| rdata | output | 8 | Byte the next read returns |
| cr_value | output | 16 | Completed count register value |
| cr_done | output | 1 | Pulse: a complete count has been written |
| cr_first | output | 1 | Pulse: first byte of a two-byte count written |
| mode_byte | output | 6 | Stored control bits 5:0 |

## Verification
A directed phase freezes the live count at known values and then changes it between latch and read, so a frozen byte can always be told apart from a live one. It runs a latch command, count-only, status-only and combined read-backs, and read-backs aimed at another channel. It also runs repeated latches before a read and interleaved read/write sequences. These show whether the status-first order, the ignore-on-repeat rule and the pointer independence hold. A control word dropped mid-sequence shows whether the latches are cancelled and the pointers reset. A random phase then lets the live count and OUT run. It mixes control words, latch commands, arbitrary command bytes, count writes, reads and load pulses, checked every clock against a queue-based reference model.

// File: rtl/tca_pkg.sv
package tca_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int CTL_W  = 6;

    typedef enum logic [1:0] {
        FMT_LATCH = 2'b00,
        FMT_LO    = 2'b01,
        FMT_HI    = 2'b10,
        FMT_BOTH  = 2'b11
    } fmt_e;

    typedef enum logic {W_LO, W_HI} wptr_e;
    typedef enum logic {RP_LO, RP_HI} rptr_e;
    typedef enum logic {OL_TRACK, OL_HOLD} olst_e;
    typedef enum logic {SL_EMPTY, SL_FULL} slst_e;

    localparam logic [CTL_W-1:0] CTL_RESET = 6'h10;
endpackage

// File: rtl/tca_cmd_decode.sv
module tca_cmd_decode #(
    parameter int CHAN_ID = 1
) (
    input  logic       cmd_we,
    input  logic [3:0] cmd_hi,
    input  logic       rb_pick,
    output logic       cw_apply,
    output logic       cnt_latch,
    output logic       stat_latch
);
    localparam logic [1:0] MY_SEL = CHAN_ID[1:0];
    localparam logic [1:0] RB_SEL = 2'b11;

    logic mine, rb_hit;

    always_comb begin
        mine       = cmd_we && (cmd_hi[3:2] == MY_SEL);
        rb_hit     = cmd_we && (cmd_hi[3:2] == RB_SEL) && rb_pick;
        cw_apply   = mine && (cmd_hi[1:0] != 2'b00);
        cnt_latch  = (mine && (cmd_hi[1:0] == 2'b00)) || (rb_hit && !cmd_hi[1]);
        stat_latch = rb_hit && !cmd_hi[0];
    end
endmodule

// File: rtl/tca_wr_path.sv
module tca_wr_path
    import tca_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_apply,
    input  logic              cnt_we,
    input  logic              load_done,
    input  fmt_e              fmt,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cr_value,
    output logic              cr_done,
    output logic              cr_first,
    output logic              null_cnt
);
    wptr_e             wp_q, wp_d;
    logic [CNT_W-1:0]  cr_q, cr_d;
    logic [BYTE_W-1:0] stage_q, stage_d;
    logic              done_q, done_d, first_q, first_d, null_q, null_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q    <= W_LO;
            cr_q    <= '0;
            stage_q <= '0;
            done_q  <= 1'b0;
            first_q <= 1'b0;
            null_q  <= 1'b0;
        end else begin
            wp_q    <= wp_d;
            cr_q    <= cr_d;
            stage_q <= stage_d;
            done_q  <= done_d;
            first_q <= first_d;
            null_q  <= null_d;
        end
    end

    always_comb begin
        wp_d    = wp_q;
        cr_d    = cr_q;
        stage_d = stage_q;
        done_d  = 1'b0;
        first_d = 1'b0;
        if (cw_apply) begin
            wp_d = W_LO;
        end else if (cnt_we) begin
            unique case (fmt)
                FMT_LO: begin
                    cr_d   = {{BYTE_W{1'b0}}, wdata};
                    done_d = 1'b1;
                end
                FMT_HI: begin
                    cr_d   = {wdata, {BYTE_W{1'b0}}};
                    done_d = 1'b1;
                end
                FMT_BOTH: begin
                    unique case (wp_q)
                        W_LO: begin
                            stage_d = wdata;
                            first_d = 1'b1;
                            wp_d    = W_HI;
                        end
                        W_HI: begin
                            cr_d   = {wdata, stage_q};
                            done_d = 1'b1;
                            wp_d   = W_LO;
                        end
                    endcase
                end
                FMT_LATCH: ;
            endcase
        end
        if (cw_apply || done_d) null_d = 1'b1;
        else if (load_done)     null_d = 1'b0;
        else                    null_d = null_q;
    end

    assign cr_value = cr_q;
    assign cr_done  = done_q;
    assign cr_first = first_q;
    assign null_cnt = null_q;

    p_lo_only_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_done && fmt == FMT_LO) |-> (cr_q[CNT_W-1:BYTE_W] == '0));
    p_first_not_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cr_first |-> !cr_done);
    p_staged_keeps_cr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cr_first |-> $stable(cr_q));
    p_null_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cr_done |-> null_q);
endmodule

// File: rtl/tca_rd_path.sv
module tca_rd_path
    import tca_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_apply,
    input  logic              cnt_latch,
    input  logic              stat_latch,
    input  logic              cnt_re,
    input  fmt_e              fmt,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic [BYTE_W-1:0] status_in,
    output logic [BYTE_W-1:0] rdata
);
    olst_e             ol_st_q, ol_st_d;
    slst_e             sl_st_q, sl_st_d;
    rptr_e             rp_q, rp_d;
    logic [CNT_W-1:0]  ol_q, ol_d;
    logic [BYTE_W-1:0] stat_q, stat_d;
    logic [CNT_W-1:0]  cnt_src;
    logic [BYTE_W-1:0] cnt_byte;
    logic              last_byte;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ol_st_q <= OL_TRACK;
            sl_st_q <= SL_EMPTY;
            rp_q    <= RP_LO;
            ol_q    <= '0;
            stat_q  <= '0;
        end else begin
            ol_st_q <= ol_st_d;
            sl_st_q <= sl_st_d;
            rp_q    <= rp_d;
            ol_q    <= ol_d;
            stat_q  <= stat_d;
        end
    end

    always_comb begin
        cnt_src = (ol_st_q == OL_HOLD) ? ol_q : live_cnt;
        unique case (fmt)
            FMT_HI:   cnt_byte = cnt_src[CNT_W-1:BYTE_W];
            FMT_BOTH: cnt_byte = (rp_q == RP_HI) ? cnt_src[CNT_W-1:BYTE_W]
                                                 : cnt_src[BYTE_W-1:0];
            default:  cnt_byte = cnt_src[BYTE_W-1:0];
        endcase
        rdata     = (sl_st_q == SL_FULL) ? stat_q : cnt_byte;
        last_byte = (fmt != FMT_BOTH) || (rp_q == RP_HI);
    end

    always_comb begin
        ol_st_d = ol_st_q;
        sl_st_d = sl_st_q;
        rp_d    = rp_q;
        ol_d    = ol_q;
        stat_d  = stat_q;
        if (cw_apply) begin
            ol_st_d = OL_TRACK;
            sl_st_d = SL_EMPTY;
            rp_d    = RP_LO;
        end else begin
            unique case (ol_st_q)
                OL_TRACK: if (cnt_latch) begin
                    ol_st_d = OL_HOLD;
                    ol_d    = live_cnt;
                end
                OL_HOLD: ;
            endcase
            unique case (sl_st_q)
                SL_EMPTY: if (stat_latch) begin
                    sl_st_d = SL_FULL;
                    stat_d  = status_in;
                end
                SL_FULL: ;
            endcase
            if (cnt_re) begin
                if (sl_st_q == SL_FULL) begin
                    sl_st_d = SL_EMPTY;
                end else begin
                    if (fmt == FMT_BOTH) rp_d = (rp_q == RP_LO) ? RP_HI : RP_LO;
                    if (last_byte)       ol_st_d = OL_TRACK;
                end
            end
        end
    end

    p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ol_st_q == OL_HOLD && $past(ol_st_q == OL_HOLD)) |-> $stable(ol_q));
    p_status_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_st_q == SL_FULL && ol_st_q == OL_HOLD && cnt_re && !cw_apply)
        |=> (ol_st_q == OL_HOLD && sl_st_q == SL_EMPTY && $stable(rp_q)));
    p_cw_cancels_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cw_apply |=> (ol_st_q == OL_TRACK && sl_st_q == SL_EMPTY && rp_q == RP_LO));
endmodule

// File: rtl/timer_chan_access.sv
module timer_chan_access
    import tca_pkg::*;
#(
    parameter int CHAN_ID = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              cnt_we,
    input  logic              cnt_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    input  logic              load_done,
    output logic [BYTE_W-1:0] rdata,
    output logic [CNT_W-1:0]  cr_value,
    output logic              cr_done,
    output logic              cr_first,
    output logic [CTL_W-1:0]  mode_byte
);
    localparam int RB_BIT = 1 + CHAN_ID;

    logic             cw_apply, cnt_latch, stat_latch, null_cnt;
    logic [CTL_W-1:0] ctl_q;
    fmt_e             fmt;

    tca_cmd_decode #(.CHAN_ID(CHAN_ID)) u_dec (
        .cmd_we    (cmd_we),
        .cmd_hi    (wdata[7:4]),
        .rb_pick   (wdata[RB_BIT]),
        .cw_apply  (cw_apply),
        .cnt_latch (cnt_latch),
        .stat_latch(stat_latch)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_q <= CTL_RESET;
        else if (cw_apply) ctl_q <= wdata[CTL_W-1:0];
    end

    assign fmt       = fmt_e'(ctl_q[5:4]);
    assign mode_byte = ctl_q;

    tca_wr_path u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_apply (cw_apply),
        .cnt_we   (cnt_we),
        .load_done(load_done),
        .fmt      (fmt),
        .wdata    (wdata),
        .cr_value (cr_value),
        .cr_done  (cr_done),
        .cr_first (cr_first),
        .null_cnt (null_cnt)
    );

    tca_rd_path u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cw_apply  (cw_apply),
        .cnt_latch (cnt_latch),
        .stat_latch(stat_latch),
        .cnt_re    (cnt_re),
        .fmt       (fmt),
        .live_cnt  (live_cnt),
        .status_in ({out_lvl, null_cnt, ctl_q}),
        .rdata     (rdata)
    );

    p_mode_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cw_apply |=> (mode_byte == $past(wdata[CTL_W-1:0])));
    p_mode_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cw_apply |=> $stable(mode_byte));
endmodule

// File: tb/timer_chan_access_tb.sv
module timer_chan_access_tb;
    localparam int CH = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0, cnt_we = 1'b0, cnt_re = 1'b0, load_done = 1'b0;
    logic [7:0]  wdata = '0;
    logic [15:0] live_cnt = 16'hABCD;
    logic        out_lvl = 1'b0;
    logic [7:0]  rdata;
    logic [15:0] cr_value;
    logic        cr_done, cr_first;
    logic [5:0]  mode_byte;

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    bit    run = 0, cmp_on = 0;
    string phase = "R11";

    always #2.5 clk = ~clk;

    timer_chan_access #(.CHAN_ID(CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cnt_we(cnt_we), .cnt_re(cnt_re),
        .wdata(wdata), .live_cnt(live_cnt), .out_lvl(out_lvl), .load_done(load_done),
        .rdata(rdata), .cr_value(cr_value), .cr_done(cr_done), .cr_first(cr_first),
        .mode_byte(mode_byte)
    );

    // reference model: queues of pending bytes
    logic [5:0]  m_ctl;
    logic [15:0] m_cr;
    logic [7:0]  m_stage;
    bit          m_wp, m_rp, m_null, m_done, m_first;
    logic [7:0]  q_st[$];
    logic [7:0]  q_cnt[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 6'h10; m_cr = '0; m_stage = '0; m_wp = 0; m_rp = 0;
            m_null = 0; m_done = 0; m_first = 0;
            q_st.delete(); q_cnt.delete();
        end else begin
            bit cw, cl, rb, rbc, rbs, comp;
            logic [1:0] f;
            logic [7:0] junk;
            f  = m_ctl[5:4];
            cw = cmd_we && wdata[7:6] == 2'(CH) && wdata[5:4] != 2'b00;
            cl = cmd_we && wdata[7:6] == 2'(CH) && wdata[5:4] == 2'b00;
            rb = cmd_we && wdata[7:6] == 2'b11 && wdata[1+CH];
            rbc = rb && !wdata[5];
            rbs = rb && !wdata[4];
            comp = 0; m_first = 0;
            if (cw) begin
                m_ctl = wdata[5:0]; q_st.delete(); q_cnt.delete(); m_rp = 0; m_wp = 0;
            end else begin
                if ((cl || rbc) && q_cnt.size() == 0) begin
                    if (f == 2'b10) q_cnt.push_back(live_cnt[15:8]);
                    else if (f == 2'b11) begin
                        if (!m_rp) q_cnt.push_back(live_cnt[7:0]);
                        q_cnt.push_back(live_cnt[15:8]);
                    end else q_cnt.push_back(live_cnt[7:0]);
                end
                if (rbs && q_st.size() == 0) q_st.push_back({out_lvl, m_null, m_ctl});
                if (cnt_we) begin
                    if (f == 2'b01) begin m_cr = {8'h00, wdata}; comp = 1; end
                    else if (f == 2'b10) begin m_cr = {wdata, 8'h00}; comp = 1; end
                    else if (f == 2'b11) begin
                        if (!m_wp) begin m_stage = wdata; m_wp = 1; m_first = 1; end
                        else begin m_cr = {wdata, m_stage}; m_wp = 0; comp = 1; end
                    end
                end
                if (cnt_re) begin
                    if (q_st.size() != 0) junk = q_st.pop_front();
                    else begin
                        if (q_cnt.size() != 0) junk = q_cnt.pop_front();
                        if (f == 2'b11) m_rp = !m_rp;
                    end
                end
            end
            m_done = comp;
            if (cw || comp) m_null = 1;
            else if (load_done) m_null = 0;
        end
    end

    function automatic logic [7:0] m_rdata();
        if (q_st.size() != 0)  return q_st[0];
        if (q_cnt.size() != 0) return q_cnt[0];
        if (m_ctl[5:4] == 2'b10) return live_cnt[15:8];
        if (m_ctl[5:4] == 2'b11 && m_rp) return live_cnt[15:8];
        return live_cnt[7:0];
    endfunction

    task automatic cmpv(string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s model %s: actual %h expected %h (t=%0t)", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            cmpv("rdata", 16'(rdata), 16'(m_rdata()));
            cmpv("cr_value", cr_value, m_cr);
            cmpv("cr_done", 16'(cr_done), 16'(m_done));
            cmpv("cr_first", 16'(cr_first), 16'(m_first));
            cmpv("mode_byte", 16'(mode_byte), 16'(m_ctl));
        end
    end

    always @(negedge clk) if (run) begin
        live_cnt <= live_cnt - 16'd1;
        out_lvl  <= 1'($urandom);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL R11 watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cmd(logic [7:0] d);
        @(negedge clk); cmd_we = 1; wdata = d;
        @(negedge clk); cmd_we = 0;
    endtask
    task automatic wr(logic [7:0] d);
        @(negedge clk); cnt_we = 1; wdata = d;
        @(negedge clk); cnt_we = 0;
    endtask
    task automatic rdchk(string tag, logic [7:0] exp);
        logic [7:0] v;
        @(negedge clk); cnt_re = 1; #1 v = rdata;
        @(negedge clk); cnt_re = 0;
        chk(tag, 16'(v), 16'(exp));
    endtask
    task automatic set_live(logic [15:0] v);
        @(negedge clk); live_cnt = v;
    endtask
    task automatic pulse_load();
        @(negedge clk); load_done = 1;
        @(negedge clk); load_done = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        cmp_on = 1;
        chk("R11 reset mode", 16'(mode_byte), 16'h0010);
        chk("R11 reset cr", cr_value, 16'h0000);
        chk("R11 reset rdata", 16'(rdata), 16'h00CD);

        phase = "R1";
        cmd(8'h76); #1 chk("R1 own control word", 16'(mode_byte), 16'h0036);
        cmd(8'h30); cmd(8'hB6); #1 chk("R1 other channel ignored", 16'(mode_byte), 16'h0036);

        phase = "R3";
        wr(8'h12); #1 chk("R3 first byte staged", cr_value, 16'h0000);
        wr(8'h34); #1 chk("R3 both bytes", cr_value, 16'h3412);

        phase = "R6";
        out_lvl = 1;
        cmd(8'hE4); rdchk("R6 R8 status after write", 8'hF6);
        pulse_load();
        cmd(8'hE4); rdchk("R8 status after load", 8'hB6);

        phase = "R4";
        set_live(16'hABCD); cmd(8'h40); set_live(16'h1111);
        rdchk("R4 latched lo", 8'hCD);
        cmd(8'h40); set_live(16'h2222);
        rdchk("R4 second latch ignored", 8'hAB);
        rdchk("R4 released lo", 8'h22);
        rdchk("R4 released hi", 8'h22);

        phase = "R7";
        set_live(16'h5678); out_lvl = 0;
        cmd(8'hC4); set_live(16'h9ABC); out_lvl = 1;
        cmd(8'hC4);
        rdchk("R7 R5 status first", 8'h36);
        rdchk("R7 count lo", 8'h78);
        rdchk("R7 count hi", 8'h56);
        rdchk("R7 live after", 8'hBC);
        rdchk("R7 live hi", 8'h9A);

        phase = "R5";
        set_live(16'h1357); cmd(8'hC2); set_live(16'h2468);
        rdchk("R5 other channel readback", 8'h68);
        rdchk("R5 other channel readback hi", 8'h24);
        set_live(16'h4321); cmd(8'hD4); set_live(16'h0000);
        rdchk("R5 count only lo", 8'h21);
        rdchk("R5 count only hi", 8'h43);

        phase = "R9";
        set_live(16'hAAAA); cmd(8'h40);
        rdchk("R9 latched lo", 8'hAA);
        cmd(8'h76); set_live(16'h5A3C);
        rdchk("R9 latch cancelled", 8'h3C);
        rdchk("R9 live hi", 8'h5A);
        wr(8'h55); cmd(8'h76); wr(8'h66); wr(8'h77);
        #1 chk("R9 write pointer reset", cr_value, 16'h7766);
        cmd(8'hE4); cmd(8'h76);
        rdchk("R9 status cancelled", 8'h3C);
        rdchk("R9 status cancelled hi", 8'h5A);

        phase = "R2";
        cmd(8'h56); wr(8'hAA); #1 chk("R2 low only", cr_value, 16'h00AA);
        rdchk("R2 low only read", 8'h3C);
        cmd(8'h66); wr(8'hBB); #1 chk("R2 high only", cr_value, 16'hBB00);
        rdchk("R2 high only read", 8'h5A);
        rdchk("R2 high only read again", 8'h5A);

        phase = "R10";
        cmd(8'h76); set_live(16'hCAFE); cmd(8'h40);
        rdchk("R10 read lo", 8'hFE);
        wr(8'h11); set_live(16'h0000);
        rdchk("R10 read hi", 8'hCA);
        wr(8'h22); #1 chk("R10 write both", cr_value, 16'h2211);
        rdchk("R10 released", 8'h00);

        phase = "R5 R7 R8 random";
        run = 1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            cmd_we = 0; cnt_we = 0; cnt_re = 0;
            load_done = ($urandom % 6) == 0;
            case ($urandom % 5)
                0: begin
                    cmd_we = 1;
                    case ($urandom % 4)
                        0: wdata = {2'(CH), 2'(1 + $urandom % 3), 3'($urandom), 1'($urandom)};
                        1: wdata = {2'(CH), 6'h00};
                        2: wdata = {2'b11, 6'($urandom)};
                        default: wdata = 8'($urandom);
                    endcase
                end
                1: begin cnt_we = 1; wdata = 8'($urandom); end
                2, 3: cnt_re = 1;
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_we = 0; cnt_we = 0; cnt_re = 0; load_done = 0;
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule